// File: doc/BRIEF.md
# Receive Frame Absorber

This block sits behind a high-rate Ethernet receive port that cannot be stalled. Beats arrive on a 512-bit streaming input that has valid, last and byte-enable signals but no ready. Every valid beat is taken in the cycle it appears. The block stores beats in a local buffer and releases a frame to the consumer only after the frame has been fully and correctly received. The consumer is typically a DMA write engine, and it may stall at any beat.

A write pointer advances speculatively while a frame arrives. On a clean final beat, the committed pointer jumps to it. Three conditions cause the frame to be thrown away: a malformed byte-enable, a length over the limit, or running out of room in the beat buffer or in the length queue. In that case the speculative pointer falls back to the last committed position and the rest of the frame is skipped. The drop counter then rises once. For each kept frame, a byte count equal to 64 times the number of full beats plus the number of set enables on the last beat goes into a separate length queue with its own handshake.

Top module: `rx_frame_absorber`

## Requirements
- R1: The output carries exactly the beats of kept frames, in arrival order, with the original data, byte enables and last marker, and nothing else.
- R2: No beat of a frame appears on the output until its last beat has been accepted; the output turns valid on the clock edge that stores the last beat of a kept frame.
- R3: While out_valid is high and out_ready is low, out_valid, out_data, out_keep and out_last hold their values; the same holds for len_valid and len_bytes under len_ready low.
- R4: A frame whose beats do not all fit in the free buffer space is discarded whole, drop_count rises by exactly one for it, and frames before and after it are delivered intact.
- R5: A frame with a non-last beat whose byte enable is not all ones, or with a last beat whose byte enable is all zeros, is discarded whole and counted once in drop_count.
- R6: A frame of at most MAX_BYTES bytes (default 9596) is kept when room allows; a frame longer than MAX_BYTES is discarded whole and counted once.
- R7: Each kept frame yields one len_bytes value equal to 64 times its count of non-last beats plus the number of ones in its last byte enable, in the same order as the frames.
- R8: After reset out_valid and len_valid are low and drop_count is zero.
- R9: A frame that ends while the length queue is full is discarded whole and counted once in drop_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present; always taken |
| in_data | input | DATA_W | Input beat payload |
| in_keep | input | DATA_W/8 | Input byte enables, bit i for byte i |
| in_last | input | 1 | Final beat of the input frame |
| out_valid | output | 1 | Committed beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | DATA_W | Output beat payload |
| out_keep | output | DATA_W/8 | Output byte enables |
| out_last | output | 1 | Final beat of the output frame |
| len_valid | output | 1 | Frame length entry available |
| len_ready | input | 1 | Consumer takes the length entry |
| len_bytes | output | $clog2(MAX_BYTES+1) | Byte length of the oldest unread kept frame |
| drop_count | output | CNT_W | Count of discarded frames, wrapping |

## Verification
A bad rollback shows up at the ports right after the discarded frame ends. It can leak beats of that frame onto the output, or shift the next frame's beats. Either way the drained beat stream no longer matches the expected frames. A wrong byte accumulator shows up as a wrong len_bytes on the next kept frame, or as a frame at the size limit being dropped. Early release of an uncommitted frame is seen as out_valid rising before the last beat, while the buffer is otherwise empty. A missed or doubled drop count appears on drop_count one edge after the final beat of the bad frame.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  // Per-beat decision taken by the ingress stage
  typedef enum logic [2:0] {
    VERDICT_IDLE,
    VERDICT_TAKE,
    VERDICT_SKIP,
    VERDICT_BADKEEP,
    VERDICT_TOOLONG,
    VERDICT_NOROOM,
    VERDICT_NOLEN
  } verdict_e;
endpackage

// File: rtl/rxa_ingress.sv
module rxa_ingress
  import rxa_pkg::*;
#(
  parameter int DATA_W    = 512,
  parameter int DEPTH     = 256,
  parameter int MAX_BYTES = 9596,
  parameter int CNT_W     = 16,
  localparam int KEEP_W   = DATA_W / 8,
  localparam int AW       = $clog2(DEPTH) + 1,
  localparam int IW       = $clog2(DEPTH),
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [KEEP_W-1:0] in_keep,
  input  logic              in_last,
  input  logic [AW-1:0]     rd_ptr,
  input  logic              lenq_full,
  output logic              wr_en,
  output logic [IW-1:0]     wr_addr,
  output logic [AW-1:0]     commit_ptr,
  output logic [AW-1:0]     spec_used,
  output logic              len_push,
  output logic [LEN_W-1:0]  len_value,
  output logic              commit_evt,
  output logic              drop_evt,
  output logic [CNT_W-1:0]  drop_count
);
  localparam int SUM_W = $clog2(MAX_BYTES + KEEP_W + 1);
  localparam int KC_W  = $clog2(KEEP_W + 1);
  localparam logic [AW-1:0]    DEPTH_P = AW'(DEPTH);
  localparam logic [SUM_W-1:0] MAX_P   = SUM_W'(MAX_BYTES);

  // number of enabled bytes in a beat
  function automatic logic [KC_W-1:0] keep_bytes(input logic [KEEP_W-1:0] k);
    logic [KC_W-1:0] n;
    n = '0;
    for (int i = 0; i < KEEP_W; i++) n = n + KC_W'(k[i]);
    return n;
  endfunction

  // inner beats must be full, the closing beat must carry at least one byte
  function automatic logic keep_legal(input logic [KEEP_W-1:0] k, input logic last);
    return last ? (k != '0) : (&k);
  endfunction

  logic [AW-1:0]    wr_spec;
  logic [SUM_W-1:0] acc_bytes;
  logic [SUM_W-1:0] new_total;
  logic             dropping;
  logic             room_full;
  logic             take;
  logic             reject;
  verdict_e         verdict;

  assign spec_used = wr_spec - rd_ptr;
  assign room_full = (spec_used == DEPTH_P);
  assign new_total = acc_bytes + SUM_W'(keep_bytes(in_keep));

  always_comb begin
    if (!in_valid)                        verdict = VERDICT_IDLE;
    else if (dropping)                    verdict = VERDICT_SKIP;
    else if (!keep_legal(in_keep, in_last)) verdict = VERDICT_BADKEEP;
    else if (new_total > MAX_P)           verdict = VERDICT_TOOLONG;
    else if (room_full)                   verdict = VERDICT_NOROOM;
    else if (in_last && lenq_full)        verdict = VERDICT_NOLEN;
    else                                  verdict = VERDICT_TAKE;
  end

  assign take       = (verdict == VERDICT_TAKE);
  assign reject     = (verdict == VERDICT_BADKEEP) || (verdict == VERDICT_TOOLONG) ||
                      (verdict == VERDICT_NOROOM)  || (verdict == VERDICT_NOLEN);
  assign commit_evt = take && in_last;
  assign drop_evt   = (reject || (verdict == VERDICT_SKIP)) && in_last;
  assign wr_en      = take;
  assign wr_addr    = wr_spec[IW-1:0];
  assign len_push   = commit_evt;
  assign len_value  = LEN_W'(new_total);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_spec    <= '0;
      commit_ptr <= '0;
      acc_bytes  <= '0;
      dropping   <= 1'b0;
      drop_count <= '0;
    end else begin
      if (take) begin
        wr_spec <= wr_spec + 1'b1;
        if (in_last) begin
          commit_ptr <= wr_spec + 1'b1;
          acc_bytes  <= '0;
        end else begin
          acc_bytes  <= new_total;
        end
      end
      if (reject) begin
        wr_spec   <= commit_ptr;
        acc_bytes <= '0;
        dropping  <= !in_last;
      end
      if ((verdict == VERDICT_SKIP) && in_last) dropping <= 1'b0;
      if (drop_evt) drop_count <= drop_count + 1'b1;
    end
  end
endmodule

// File: rtl/rxa_beat_store.sv
module rxa_beat_store #(
  parameter int WIDTH = 577,
  parameter int DEPTH = 256,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rxa_egress.sv
module rxa_egress #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH) + 1,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] commit_ptr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] rd_ptr,
  output logic [IW-1:0] rd_addr
);
  assign out_valid = (rd_ptr != commit_ptr);
  assign rd_addr   = rd_ptr[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                      rd_ptr <= '0;
    else if (out_valid && out_ready) rd_ptr <= rd_ptr + 1'b1;
  end
endmodule

// File: rtl/rxa_len_fifo.sv
module rxa_len_fifo #(
  parameter int WIDTH = 14,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH) + 1,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             full,
  output logic             valid,
  input  logic             ready,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0]    wp;
  logic [AW-1:0]    rp;

  assign full  = (wp - rp) == AW'(DEPTH);
  assign valid = (wp != rp);
  assign dout  = slots[rp[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) slots[wp[IW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (valid && ready) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/rx_frame_absorber.sv
module rx_frame_absorber #(
  parameter int DATA_W    = 512,
  parameter int DEPTH     = 256,
  parameter int MAX_BYTES = 9596,
  parameter int LQ_DEPTH  = 16,
  parameter int CNT_W     = 16,
  localparam int KEEP_W   = DATA_W / 8,
  localparam int AW       = $clog2(DEPTH) + 1,
  localparam int IW       = $clog2(DEPTH),
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int ENT_W    = DATA_W + KEEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [KEEP_W-1:0] in_keep,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [KEEP_W-1:0] out_keep,
  output logic              out_last,
  output logic              len_valid,
  input  logic              len_ready,
  output logic [LEN_W-1:0]  len_bytes,
  output logic [CNT_W-1:0]  drop_count
);
  logic             wr_en;
  logic [IW-1:0]    wr_addr;
  logic [IW-1:0]    rd_addr;
  logic [AW-1:0]    commit_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [AW-1:0]    spec_used;
  logic             len_push;
  logic [LEN_W-1:0] len_value;
  logic             lenq_full;
  logic             commit_evt;
  logic             drop_evt;
  logic [ENT_W-1:0] rd_entry;

  rxa_ingress #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
  ) ingress_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_keep(in_keep), .in_last(in_last),
    .rd_ptr(rd_ptr), .lenq_full(lenq_full),
    .wr_en(wr_en), .wr_addr(wr_addr), .commit_ptr(commit_ptr),
    .spec_used(spec_used), .len_push(len_push), .len_value(len_value),
    .commit_evt(commit_evt), .drop_evt(drop_evt), .drop_count(drop_count)
  );

  rxa_beat_store #(.WIDTH(ENT_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data({in_last, in_keep, in_data}),
    .rd_addr(rd_addr), .rd_data(rd_entry)
  );

  rxa_egress #(.DEPTH(DEPTH)) egress_i (
    .clk(clk), .rst_n(rst_n), .commit_ptr(commit_ptr), .out_ready(out_ready),
    .out_valid(out_valid), .rd_ptr(rd_ptr), .rd_addr(rd_addr)
  );

  rxa_len_fifo #(.WIDTH(LEN_W), .DEPTH(LQ_DEPTH)) lenq_i (
    .clk(clk), .rst_n(rst_n), .push(len_push), .din(len_value), .full(lenq_full),
    .valid(len_valid), .ready(len_ready), .dout(len_bytes)
  );

  assign {out_last, out_keep, out_data} = rd_entry;
endmodule

// File: rtl/rx_frame_absorber_chk.sv
module rx_frame_absorber_chk #(
  parameter int DATA_W    = 512,
  parameter int DEPTH     = 256,
  parameter int MAX_BYTES = 9596,
  parameter int CNT_W     = 16,
  localparam int KEEP_W   = DATA_W / 8,
  localparam int AW       = $clog2(DEPTH) + 1,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [KEEP_W-1:0] out_keep,
  input logic              out_last,
  input logic              len_valid,
  input logic              len_ready,
  input logic [LEN_W-1:0]  len_bytes,
  input logic [CNT_W-1:0]  drop_count,
  input logic [AW-1:0]     spec_used,
  input logic              commit_evt,
  input logic              drop_evt,
  input logic              len_push,
  input logic [LEN_W-1:0]  len_value
);
  localparam logic [AW-1:0]    DEPTH_P = AW'(DEPTH);
  localparam logic [LEN_W-1:0] MAX_P   = LEN_W'(MAX_BYTES);

  assert_commit_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (in_valid && in_last));

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && out_data == $past(out_data) &&
                                   out_keep == $past(out_keep) && out_last == $past(out_last)));

  assert_len_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (len_valid && !len_ready) |=> (len_valid && $stable(len_bytes)));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spec_used <= DEPTH_P);

  assert_drop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (drop_count == CNT_W'($past(drop_count) + 1'b1)));

  assert_drop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> $stable(drop_count));

  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_evt && drop_evt));

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    len_push |-> (len_value <= MAX_P && len_value != '0));
endmodule

bind rx_frame_absorber rx_frame_absorber_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_keep(out_keep), .out_last(out_last), .len_valid(len_valid),
  .len_ready(len_ready), .len_bytes(len_bytes), .drop_count(drop_count),
  .spec_used(spec_used), .commit_evt(commit_evt), .drop_evt(drop_evt),
  .len_push(len_push), .len_value(len_value)
);

// File: tb/rx_frame_absorber_tb_top.sv
module rx_frame_absorber_tb_top;
  localparam int DATA_W = 512;
  localparam int KEEP_W = 64;
  localparam int DEPTH  = 16;
  localparam int MAXB   = 640;
  localparam int LQD    = 4;
  localparam int CNT_W  = 16;
  localparam int LEN_W  = $clog2(MAXB + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [KEEP_W-1:0] in_keep = '0;
  logic              in_last = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic [KEEP_W-1:0] out_keep;
  logic              out_last;
  logic              len_valid;
  logic              len_ready = 1'b0;
  logic [LEN_W-1:0]  len_bytes;
  logic [CNT_W-1:0]  drop_count;

  int total = 0;
  int bad   = 0;

  logic [DATA_W-1:0] exp_data [$];
  logic [KEEP_W-1:0] exp_keep [$];
  logic              exp_last [$];
  int                exp_len  [$];

  always #4 clk = ~clk;

  rx_frame_absorber #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .MAX_BYTES(MAXB), .LQ_DEPTH(LQD), .CNT_W(CNT_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_keep(in_keep), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_keep(out_keep),
    .out_last(out_last), .len_valid(len_valid), .len_ready(len_ready),
    .len_bytes(len_bytes), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int fid, input int b);
    logic [15:0] f;
    logic [15:0] k;
    f = fid[15:0];
    k = b[15:0];
    return {16{f, k}};
  endfunction

  // drive one frame back to back from a falling edge; ends on a falling edge
  task automatic send_frame(input int fid, input int nbeats, input logic [63:0] last_keep,
                            input int bad_at, input bit kept, input bit hidden);
    for (int b = 0; b < nbeats; b++) begin
      if (hidden && b > 0) check(out_valid == 1'b0, "R2 early release", 64'(out_valid), 0);
      in_valid = 1'b1;
      in_data  = pat(fid, b);
      in_last  = (b == nbeats - 1);
      in_keep  = in_last ? last_keep : ((b == bad_at) ? 64'h00FF : '1);
      if (kept) begin
        exp_data.push_back(in_data);
        exp_keep.push_back(in_keep);
        exp_last.push_back(in_last);
      end
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (kept) exp_len.push_back((nbeats - 1) * 64 + $countones(last_keep));
  endtask

  task automatic drain(input string req);
    int guard = 0;
    out_ready = 1'b1;
    len_ready = 1'b1;
    while ((exp_data.size() > 0 || exp_len.size() > 0) && guard < 400) begin
      if (out_valid) begin
        if (exp_data.size() == 0) check(1'b0, {req, " R1 extra beat"}, out_data[63:0], 0);
        else begin
          check(out_data == exp_data[0] && out_keep == exp_keep[0] && out_last == exp_last[0],
                {req, " R1 beat"}, out_data[63:0], exp_data[0][63:0]);
          void'(exp_data.pop_front());
          void'(exp_keep.pop_front());
          void'(exp_last.pop_front());
        end
      end
      if (len_valid) begin
        if (exp_len.size() == 0) check(1'b0, {req, " R7 extra length"}, 64'(len_bytes), 0);
        else begin
          check(int'(len_bytes) == exp_len[0], {req, " R7 length"}, 64'(len_bytes),
                64'(exp_len[0]));
          void'(exp_len.pop_front());
        end
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
    len_ready = 1'b0;
    check(guard < 400, {req, " R1 missing output"}, 64'(exp_data.size()), 0);
    check(!out_valid && !len_valid, {req, " R1 leftover"}, 64'({out_valid, len_valid}), 0);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R8 out_valid", 64'(out_valid), 0);
    check(len_valid == 1'b0, "R8 len_valid", 64'(len_valid), 0);
    check(drop_count == '0, "R8 drop_count", 64'(drop_count), 0);
  endtask

  task automatic t_basic();
    send_frame(1, 3, 64'h0F, -1, 1'b1, 1'b1);
    check(out_valid == 1'b1, "R2 valid after last", 64'(out_valid), 1);
    drain("basic");
  endtask

  task automatic t_stall();
    logic [DATA_W-1:0] d0;
    logic [LEN_W-1:0]  l0;
    send_frame(2, 2, '1, -1, 1'b1, 1'b0);
    d0 = out_data;
    l0 = len_bytes;
    repeat (3) @(negedge clk);
    check(out_valid && out_data == d0 && !out_last, "R3 beat hold", out_data[63:0], d0[63:0]);
    check(len_valid && len_bytes == l0, "R3 length hold", 64'(len_bytes), 64'(l0));
    drain("stall");
  endtask

  task automatic t_mixed();
    send_frame(3, 1, '1, -1, 1'b1, 1'b0);
    send_frame(4, 2, 64'h1, -1, 1'b1, 1'b0);
    send_frame(5, 4, 64'h7FFF_FFFF, -1, 1'b1, 1'b0);
    drain("mixed R7");
  endtask

  task automatic t_overflow();
    logic [CNT_W-1:0] d0;
    d0 = drop_count;
    send_frame(6, 10, '1, -1, 1'b1, 1'b0);  // 640 bytes, the size limit (R6)
    send_frame(7, 8, '1, -1, 1'b0, 1'b0);   // only 6 slots left
    check(drop_count == d0 + 1'b1, "R4 drop once", 64'(drop_count), 64'(d0 + 1'b1));
    send_frame(8, 5, 64'h3, -1, 1'b1, 1'b0);
    check(drop_count == d0 + 1'b1, "R4 no extra drop", 64'(drop_count), 64'(d0 + 1'b1));
    drain("overflow R4");
  endtask

  task automatic t_badkeep();
    logic [CNT_W-1:0] d0;
    d0 = drop_count;
    send_frame(9, 3, '1, 1, 1'b0, 1'b0);
    check(drop_count == d0 + 1'b1, "R5 inner partial", 64'(drop_count), 64'(d0 + 1'b1));
    check(out_valid == 1'b0, "R5 nothing released", 64'(out_valid), 0);
    send_frame(10, 1, 64'h0, -1, 1'b0, 1'b0);
    check(drop_count == d0 + 2'd2, "R5 empty last", 64'(drop_count), 64'(d0 + 2'd2));
    send_frame(11, 2, 64'hFF, -1, 1'b1, 1'b0);
    drain("badkeep R5");
  endtask

  task automatic t_oversize();
    logic [CNT_W-1:0] d0;
    d0 = drop_count;
    send_frame(12, 11, 64'h1, -1, 1'b0, 1'b0);
    check(drop_count == d0 + 1'b1, "R6 oversize", 64'(drop_count), 64'(d0 + 1'b1));
    check(out_valid == 1'b0, "R6 nothing released", 64'(out_valid), 0);
    send_frame(13, 1, 64'h3, -1, 1'b1, 1'b0);
    drain("oversize R6");
  endtask

  task automatic t_lenfull();
    logic [CNT_W-1:0] d0;
    d0 = drop_count;
    for (int i = 0; i < LQD; i++) send_frame(20 + i, 1, '1, -1, 1'b1, 1'b0);
    send_frame(30, 1, '1, -1, 1'b0, 1'b0);
    check(drop_count == d0 + 1'b1, "R9 length queue full", 64'(drop_count), 64'(d0 + 1'b1));
    drain("lenfull R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_stall();
    t_mixed();
    t_overflow();
    t_badkeep();
    t_oversize();
    t_lenfull();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule